// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control store of an eight-channel DMA controller. A processor reaches it over a plain 32-bit read/write bus that carries a byte offset. Each per-channel attribute is held in one bitmap: burst-only mode, request mask, channel enable, alternate descriptor select and high priority. Software changes a bitmap through two write addresses. A 1 written to the set address sets the bit, and a 1 written to the clear address clears it. A 0 written to either address leaves the bit alone. Because of this, software never needs a read-modify-write sequence.

The bank also holds several other registers:
- a sticky completion flag for each channel;
- a sticky bus-error flag, which software clears by writing 1;
- a done-mask bitmap;
- a configuration word with the master enable and the bus protection bits;
- the descriptor base pointer.

The alternate descriptor base is derived from the base pointer. The sequencer state, the hardware completion and error events, and the wait-on-request status come in on ports. The bitmaps, flags, configuration and a one-cycle software request pulse go out on ports to the transfer engine.

Top module: `dmac_regbank`

## Requirements
- R1: After reset every bitmap, flag, the configuration, the base pointer and the software request output are zero.
- R2: A write to a set address (burst 0x18, mask 0x20, enable 0x28, alternate 0x30, priority 0x38) sets each bitmap bit whose data bit is 1 and leaves the others. A read of the set address returns the bitmap in bits [7:0], and the bitmap also drives its output port.
- R3: A write to the matching clear address (the set address plus 4) clears each bit whose data bit is 1 and leaves the others. Clear addresses read as zero.
- R4: Data bits above the implemented channel count (bits [31:8]) have no effect on any bitmap or flag, and they read as zero.
- R5: The status word at 0x00 reads the channel count minus one in bits [20:16], the sequencer state input in bits [7:4], and the master enable in bit 0. All other status bits are zero.
- R6: The configuration word at 0x04 stores the master enable in bit 0 and the protection bits in [7:5]. Bit 7 is cacheable, bit 6 bufferable and bit 5 privileged, and these bits drive `prot_ctrl[2:0]` in that order.
- R7: The base pointer at 0x08 keeps only bits [31:8], and bits [7:0] read as zero. The alternate base at 0x0C reads the base pointer plus 0x80 and ignores writes.
- R8: A completion bit at 0x504 sets when its `done_set` input is 1. It holds until software writes 1 to it, and a write of 0 has no effect. If a hardware set and a software clear meet in the same cycle, the bit stays set.
- R9: The error flag at 0x4C bit 0 sets when `err_set` is 1 and clears only when software writes 1 to it.
- R10: A write to 0x14 drives `sw_req` with the written channel bits for exactly the next cycle. Afterwards `sw_req` returns to zero, and 0x14 reads as zero.
- R11: The done mask at 0x520 is an ordinary read/write bitmap. Reads of offsets that are not mapped return zero.
- R12: A read of 0x10 returns the `wait_req` input bitmap in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid while it is high |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| seq_state | input | 4 | Sequencer state code |
| wait_req | input | 8 | Wait-on-request status for each channel |
| done_set | input | 8 | Completion event for each channel |
| err_set | input | 1 | Bus error event |
| master_en | output | 1 | Controller enable |
| prot_ctrl | output | 3 | Cacheable, bufferable, privileged |
| base_pri | output | 32 | Primary descriptor base |
| base_alt | output | 32 | Alternate descriptor base |
| burst_only | output | 8 | Burst-only bitmap |
| req_mask | output | 8 | Request mask bitmap |
| chan_en | output | 8 | Channel enable bitmap |
| alt_sel | output | 8 | Alternate select bitmap |
| hi_prio | output | 8 | High priority bitmap |
| done_mask | output | 8 | Done mask bitmap |
| done_flags | output | 8 | Sticky completion flags |
| err_flag | output | 1 | Sticky bus error flag |
| sw_req | output | 8 | Software request pulse |

## Verification
The assertions assume the bus issues at most one write per cycle, to a single word-aligned offset. Under that assumption, a set strobe and a clear strobe for the same bitmap never occur together. They also assume that `done_set` and `err_set` are clean synchronous pulses. The bench drives every input at the falling edge and only ever performs one write per task call, so it stays inside these assumptions. It does drive a hardware set and a software clear into the same cycle on purpose, to check the precedence rule.

// File: rtl/dmac_regbank_pkg.sv
package dmac_regbank_pkg;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned NMAPS  = 5;

   localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_CONFIG = 12'h004;
   localparam logic [ADDR_W-1:0] OFS_BASE   = 12'h008;
   localparam logic [ADDR_W-1:0] OFS_ALT    = 12'h00C;
   localparam logic [ADDR_W-1:0] OFS_WAIT   = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_SWREQ  = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_MAP0   = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_ERROR  = 12'h04C;
   localparam logic [ADDR_W-1:0] OFS_DONE   = 12'h504;
   localparam logic [ADDR_W-1:0] OFS_DMASK  = 12'h520;

   // map index order: burst, mask, enable, alternate, priority
   function automatic logic [ADDR_W-1:0] set_ofs(input int unsigned k);
      return OFS_MAP0 + ADDR_W'(8 * k);
   endfunction

   function automatic logic [ADDR_W-1:0] clr_ofs(input int unsigned k);
      return OFS_MAP0 + ADDR_W'(8 * k + 4);
   endfunction
endpackage

// File: rtl/dmac_setclr_map.sv
module dmac_setclr_map #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_we,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] wbits,
   output logic [WIDTH-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_we) q <= q | wbits;
      else if (clr_we) q <= q & ~wbits;
   end

   assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((q & $past(wbits)) == $past(wbits)));
   assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((q & $past(wbits)) == '0));
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/dmac_sticky_w1c.sv
module dmac_sticky_w1c #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hw_set,
   input  logic             clr_we,
   input  logic [WIDTH-1:0] clr_bits,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] clr_eff;
   assign clr_eff = clr_we ? clr_bits : '0;

   // hardware set takes precedence over a same-cycle software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_eff) | hw_set;
   end

   assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set != '0) |=> ((q & $past(hw_set)) == $past(hw_set)));
   assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_we && hw_set == '0) |=> $stable(q));
endmodule

// File: rtl/dmac_regbank.sv
module dmac_regbank
   import dmac_regbank_pkg::*;
#(
   parameter int unsigned NCH        = 8,
   parameter int unsigned DW         = 32,
   parameter int unsigned DESC_BYTES = 16,
   parameter int unsigned BASE_LSB   = 8,
   parameter int unsigned STATE_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic [STATE_W-1:0] seq_state,
   input  logic [NCH-1:0]    wait_req,
   input  logic [NCH-1:0]    done_set,
   input  logic              err_set,
   output logic              master_en,
   output logic [2:0]        prot_ctrl,
   output logic [DW-1:0]     base_pri,
   output logic [DW-1:0]     base_alt,
   output logic [NCH-1:0]    burst_only,
   output logic [NCH-1:0]    req_mask,
   output logic [NCH-1:0]    chan_en,
   output logic [NCH-1:0]    alt_sel,
   output logic [NCH-1:0]    hi_prio,
   output logic [NCH-1:0]    done_mask,
   output logic [NCH-1:0]    done_flags,
   output logic              err_flag,
   output logic [NCH-1:0]    sw_req
);
   localparam int unsigned CNT_W    = 5;
   localparam int unsigned ALT_SPAN = NCH * DESC_BYTES;
   localparam int unsigned BASE_W   = DW - BASE_LSB;

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $error("NCH must lie in 1..32");
   end
   if (DW != 32) begin : g_bad_dw
      $error("DW must be 32");
   end
   if ((DESC_BYTES & (DESC_BYTES - 1)) != 0) begin : g_bad_desc
      $error("DESC_BYTES must be a power of two");
   end
   if (ALT_SPAN > (1 << BASE_LSB)) begin : g_bad_span
      $error("alternate span exceeds base alignment");
   end

   logic [NCH-1:0] chan_bits;
   assign chan_bits = bus_wdata[NCH-1:0];

   // ---------------- set/clear bitmaps ----------------
   logic [NMAPS-1:0][NCH-1:0] map_q;

   for (genvar k = 0; k < NMAPS; k++) begin : g_map
      logic set_hit, clr_hit;
      assign set_hit = bus_wr && (bus_addr == set_ofs(k));
      assign clr_hit = bus_wr && (bus_addr == clr_ofs(k));
      dmac_setclr_map #(.WIDTH(NCH)) u_map (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (set_hit),
         .clr_we (clr_hit),
         .wbits  (chan_bits),
         .q      (map_q[k])
      );
   end

   assign burst_only = map_q[0];
   assign req_mask   = map_q[1];
   assign chan_en    = map_q[2];
   assign alt_sel    = map_q[3];
   assign hi_prio    = map_q[4];

   // ---------------- sticky flags ----------------
   logic done_clr_we, err_clr_we;
   assign done_clr_we = bus_wr && (bus_addr == OFS_DONE);
   assign err_clr_we  = bus_wr && (bus_addr == OFS_ERROR);

   dmac_sticky_w1c #(.WIDTH(NCH)) u_done (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (done_set),
      .clr_we   (done_clr_we),
      .clr_bits (chan_bits),
      .q        (done_flags)
   );

   dmac_sticky_w1c #(.WIDTH(1)) u_err (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (err_set),
      .clr_we   (err_clr_we),
      .clr_bits (bus_wdata[0]),
      .q        (err_flag)
   );

   // ---------------- plain registers ----------------
   logic [BASE_W-1:0] base_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_en <= 1'b0;
         prot_ctrl <= '0;
         base_hi   <= '0;
         done_mask <= '0;
         sw_req    <= '0;
      end else begin
         sw_req <= '0;
         if (bus_wr) begin
            unique case (bus_addr)
               OFS_CONFIG: begin
                  master_en <= bus_wdata[0];
                  prot_ctrl <= bus_wdata[7:5];
               end
               OFS_BASE:  base_hi   <= bus_wdata[DW-1:BASE_LSB];
               OFS_DMASK: done_mask <= chan_bits;
               OFS_SWREQ: sw_req    <= chan_bits;
               default: ;
            endcase
         end
      end
   end

   assign base_pri = {base_hi, {BASE_LSB{1'b0}}};
   assign base_alt = base_pri + DW'(ALT_SPAN);

   // ---------------- read mux ----------------
   logic [DW-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      case (bus_addr)
         OFS_STATUS: begin
            rd_word[16 +: CNT_W]   = CNT_W'(NCH - 1);
            rd_word[4 +: STATE_W]  = seq_state;
            rd_word[0]             = master_en;
         end
         OFS_CONFIG: begin
            rd_word[7:5] = prot_ctrl;
            rd_word[0]   = master_en;
         end
         OFS_BASE:  rd_word = base_pri;
         OFS_ALT:   rd_word = base_alt;
         OFS_WAIT:  rd_word[NCH-1:0] = wait_req;
         OFS_ERROR: rd_word[0] = err_flag;
         OFS_DONE:  rd_word[NCH-1:0] = done_flags;
         OFS_DMASK: rd_word[NCH-1:0] = done_mask;
         default: begin
            for (int k = 0; k < NMAPS; k++) begin
               if (bus_addr == set_ofs(k)) rd_word[NCH-1:0] = map_q[k];
            end
         end
      endcase
   end

   assign bus_rdata = bus_rd ? rd_word : '0;

   assert_swreq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req != '0) |-> $past(bus_wr && bus_addr == OFS_SWREQ));
   assert_swreq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req != '0 && !(bus_wr && bus_addr == OFS_SWREQ)) |=> (sw_req == '0));
   assert_alt_readonly_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == OFS_ALT) |=> $stable(base_alt));
endmodule

// File: tb/dmac_regbank_tb.sv
module dmac_regbank_tb;
   import dmac_regbank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  seq_state = 4'h5;
   logic [7:0]  wait_req = 8'h00;
   logic [7:0]  done_set = 8'h00;
   logic        err_set = 1'b0;
   logic        master_en, err_flag;
   logic [2:0]  prot_ctrl;
   logic [31:0] base_pri, base_alt;
   logic [7:0]  burst_only, req_mask, chan_en, alt_sel, hi_prio;
   logic [7:0]  done_mask, done_flags, sw_req;

   int errs = 0;
   int checks = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   dmac_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .seq_state(seq_state), .wait_req(wait_req), .done_set(done_set),
      .err_set(err_set), .master_en(master_en), .prot_ctrl(prot_ctrl),
      .base_pri(base_pri), .base_alt(base_alt), .burst_only(burst_only),
      .req_mask(req_mask), .chan_en(chan_en), .alt_sel(alt_sel),
      .hi_prio(hi_prio), .done_mask(done_mask), .done_flags(done_flags),
      .err_flag(err_flag), .sw_req(sw_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   function automatic logic [7:0] map_port(input int k);
      case (k)
         0: return burst_only;
         1: return req_mask;
         2: return chan_en;
         3: return alt_sel;
         default: return hi_prio;
      endcase
   endfunction

   initial begin
      while (cycles < 100000) begin
         @(posedge clk);
         cycles++;
      end
      errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [7:0]  m;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 bitmaps", {burst_only, req_mask, chan_en, alt_sel}, 32'h0);
      chk("R1 flags", {hi_prio, done_mask, done_flags, sw_req}, 32'h0);
      chk("R1 cfg", {28'h0, err_flag, prot_ctrl}, 32'h0);
      chk("R1 base", base_pri, 32'h0);
      chk("R1 enable", {31'h0, master_en}, 32'h0);

      // R5 status
      rd(OFS_STATUS, d); chk("R5 status", d, (32'd7 << 16) | (32'h5 << 4));

      // R2 R3 R4 sweep over all bitmaps and channels
      for (int k = 0; k < NMAPS; k++) begin
         logic [11:0] sa, ca;
         sa = 12'h018 + 12'(8 * k);
         ca = sa + 12'h4;
         m = 8'h00;
         wr(sa, 32'hFFFF_FF00);
         rd(sa, d); chk("R4 upper bits ignored", d, 32'h0);
         wr(sa, 32'h0000_00A5); m = 8'hA5;
         rd(sa, d); chk("R2 set pattern", d, {24'h0, m});
         wr(sa, 32'h0); rd(sa, d); chk("R2 zero write", d, {24'h0, m});
         for (int ch = 0; ch < 8; ch++) begin
            wr(ca, 32'h1 << ch); m = m & ~(8'h1 << ch);
            rd(sa, d); chk("R3 clear bit", d, {24'h0, m});
            chk("R3 port", {24'h0, map_port(k)}, {24'h0, m});
            wr(sa, 32'h1 << ch); m = m | (8'h1 << ch);
            rd(sa, d); chk("R2 set bit", d, {24'h0, m});
            chk("R2 port", {24'h0, map_port(k)}, {24'h0, m});
         end
         rd(ca, d); chk("R3 clear addr reads 0", d, 32'h0);
         wr(ca, 32'hFFFF_FF00); rd(sa, d); chk("R4 clear upper ignored", d, 32'hFF);
         wr(ca, 32'hFF); rd(sa, d); chk("R3 clear all", d, 32'h0);
      end

      // R6 config
      wr(OFS_CONFIG, 32'hFFFF_FFA1);
      rd(OFS_CONFIG, d); chk("R6 config read", d, 32'hA1);
      chk("R6 prot port", {29'h0, prot_ctrl}, 32'h5);
      chk("R6 enable port", {31'h0, master_en}, 32'h1);
      rd(OFS_STATUS, d); chk("R5 status enable", d, (32'd7 << 16) | (32'h5 << 4) | 32'h1);
      seq_state = 4'hA; #1;
      rd(OFS_STATUS, d); chk("R5 status state", d, (32'd7 << 16) | (32'hA << 4) | 32'h1);

      // R7 base pointers
      wr(OFS_BASE, 32'h1234_5678);
      rd(OFS_BASE, d); chk("R7 base", d, 32'h1234_5600);
      rd(OFS_ALT, d); chk("R7 alt", d, 32'h1234_5680);
      wr(OFS_ALT, 32'h0);
      rd(OFS_ALT, d); chk("R7 alt read-only", d, 32'h1234_5680);
      chk("R7 alt port", base_alt, 32'h1234_5680);

      // R8 completion flags
      @(negedge clk); done_set = 8'h81;
      @(negedge clk); done_set = 8'h00;
      rd(OFS_DONE, d); chk("R8 done set", d, 32'h81);
      wr(OFS_DONE, 32'h0); rd(OFS_DONE, d); chk("R8 zero write", d, 32'h81);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = OFS_DONE; bus_wdata = 32'h81; done_set = 8'h01;
      @(negedge clk);
      bus_wr = 1'b0; done_set = 8'h00;
      rd(OFS_DONE, d); chk("R8 set wins", d, 32'h01);
      wr(OFS_DONE, 32'h01); rd(OFS_DONE, d); chk("R8 w1c", d, 32'h0);

      // R9 error flag
      @(negedge clk); err_set = 1'b1;
      @(negedge clk); err_set = 1'b0;
      repeat (2) @(negedge clk);
      rd(OFS_ERROR, d); chk("R9 error sticky", d, 32'h1);
      wr(OFS_ERROR, 32'h0); rd(OFS_ERROR, d); chk("R9 zero write", d, 32'h1);
      wr(OFS_ERROR, 32'h1); rd(OFS_ERROR, d); chk("R9 w1c", d, 32'h0);

      // R10 software request pulse
      wr(OFS_SWREQ, 32'hFFFF_FF3C);
      chk("R10 pulse", {24'h0, sw_req}, 32'h3C);
      @(negedge clk);
      chk("R10 pulse ends", {24'h0, sw_req}, 32'h0);
      rd(OFS_SWREQ, d); chk("R10 reads zero", d, 32'h0);

      // R11 done mask and unmapped
      wr(OFS_DMASK, 32'hFFFF_FF5A);
      rd(OFS_DMASK, d); chk("R11 done mask", d, 32'h5A);
      chk("R11 done mask port", {24'h0, done_mask}, 32'h5A);
      rd(12'h040, d); chk("R11 unmapped", d, 32'h0);
      rd(12'h600, d); chk("R11 unmapped high", d, 32'h0);

      // R12 wait-on-request
      wait_req = 8'hC3; #1;
      rd(OFS_WAIT, d); chk("R12 wait status", d, 32'hC3);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule